// File: doc/BRIEF.md
# Read-Sequence Write-Protect Guard

This block sits beside a parallel memory bus and decides whether the memory behind it may be written. It owns a single write-protect flag that comes out of reset in the protected state. Software changes the flag without writing anything: it issues seven read cycles in a row whose addresses form a fixed pattern. One pattern removes protection. A second pattern shares the first six addresses, differs only in the last one, and restores protection.

The chip-enable, output-enable and write-enable strobes and the address bus come from outside the system clock domain. They pass through a synchronizer chain, and the block detects the end of each read cycle from the synchronized samples. The address of a read is the value present while the cycle was still active, just before the first of the two read strobes went high. Only the low thirteen address bits are compared. A read that does not fit the pattern restarts the search, and a write cycle throws away any partial progress. Each completed pattern gives a one-cycle pulse.

Top module: `rdseq_guard`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `prot_o` is 1 and `done_o` is 0.
- R2: Seven back-to-back reads at low addresses 0x1823, 0x1820, 0x1822, 0x0418, 0x041B, 0x0419, 0x041A set `prot_o` to 0.
- R3: The same first six addresses followed by 0x040A as the seventh read set `prot_o` to 1.
- R4: A read ends when chip enable or output enable rises while both were low and write enable was high (strobes active low). The address counted is the one present before that first rise. A later rise of the other strobe, or an address change after the first rise, has no effect.
- R5: Address bits 13 and up never affect matching.
- R6: A read that does not fit the next step restarts matching. If its address is 0x1823, it counts as the first step of a new attempt.
- R7: A write cycle (chip enable and write enable low, output enable high) discards partial progress, so a pattern broken by a write leaves `prot_o` unchanged.
- R8: `done_o` is high for exactly one cycle per completed pattern. It is never high in two cycles in a row, and `prot_o` changes only in a cycle where `done_o` is high.
- R9: Completing a pattern whose result equals the current flag state still pulses `done_o`, and `prot_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable, active low, asynchronous |
| bus_we_n | input | 1 | Write enable, active low, asynchronous |
| bus_addr | input | ADDR_W | Memory address bus, asynchronous |
| prot_o | output | 1 | Write-protect flag, 1 means protected |
| done_o | output | 1 | One-cycle pulse when a pattern completes |

## Verification
The hardest case to create is a read that ends with the two read strobes rising at different times while the address changes between the two rises. Only this case shows which edge the block uses to take the address. The stimulus drives each read in one of four styles: chip enable held low, output enable held low, output enable rising first, and chip enable rising first. Right after the first rise it moves the address to a wrong value, so a design that takes the later edge fails the pattern. The stimulus also sets the upper address bits to random values, breaks patterns with writes and with stray reads, and repeats the first address to exercise the restart rule.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    localparam int MATCH_W    = 13;
    localparam int STEP_COUNT = 7;
    localparam int PREFIX_LEN = STEP_COUNT - 1;
    localparam int STEP_W     = $clog2(STEP_COUNT + 1);

    localparam logic [MATCH_W-1:0] TAIL_OPEN  = 13'h041A;
    localparam logic [MATCH_W-1:0] TAIL_CLOSE = 13'h040A;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

    typedef struct packed {
        logic               valid;
        logic [MATCH_W-1:0] addr;
    } read_evt_t;

    typedef enum logic [1:0] {
        VERDICT_NONE  = 2'd0,
        VERDICT_OPEN  = 2'd1,
        VERDICT_CLOSE = 2'd2
    } verdict_e;

    function automatic logic [MATCH_W-1:0] prefix_addr(input logic [STEP_W-1:0] idx);
        logic [MATCH_W-1:0] r;
        case (idx)
            3'd0:    r = 13'h1823;
            3'd1:    r = 13'h1820;
            3'd2:    r = 13'h1822;
            3'd3:    r = 13'h0418;
            3'd4:    r = 13'h041B;
            3'd5:    r = 13'h0419;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic is_read(input strobe_t s);
        return !s.ce_n && !s.oe_n && s.we_n;
    endfunction

    function automatic logic is_write(input strobe_t s);
        return !s.ce_n && !s.we_n && s.oe_n;
    endfunction

endpackage

// File: rtl/rdseq_sync.sv
module rdseq_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/rdseq_cycle_decode.sv
module rdseq_cycle_decode
    import rdseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  strobe_t            strb,
    input  logic [MATCH_W-1:0] addr,
    output read_evt_t          evt,
    output logic               write_seen
);

    strobe_t            prev_strb;
    logic [MATCH_W-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_strb <= STROBE_IDLE;
            prev_addr <= '0;
        end else begin
            prev_strb <= strb;
            prev_addr <= addr;
        end
    end

    // A read closes on the first read strobe to rise; the address is the
    // one sampled while the cycle was still active.
    always_comb begin
        evt.valid = is_read(prev_strb) && (strb.ce_n || strb.oe_n);
        evt.addr  = prev_addr;
    end

    assign write_seen = is_write(strb);

endmodule

// File: rtl/rdseq_matcher.sv
module rdseq_matcher
    import rdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  read_evt_t         evt,
    input  logic              write_seen,
    output verdict_e          verdict,
    output logic [STEP_W-1:0] prog
);

    localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(PREFIX_LEN);

    logic [STEP_W-1:0] prog_nxt;
    logic [STEP_W-1:0] restart_val;

    always_comb begin
        restart_val = (evt.addr == prefix_addr('0)) ? STEP_W'(1) : '0;
        prog_nxt    = prog;
        verdict     = VERDICT_NONE;
        if (write_seen) begin
            prog_nxt = '0;
        end else if (evt.valid) begin
            if (prog == LAST_IDX) begin
                if (evt.addr == TAIL_OPEN) begin
                    verdict  = VERDICT_OPEN;
                    prog_nxt = '0;
                end else if (evt.addr == TAIL_CLOSE) begin
                    verdict  = VERDICT_CLOSE;
                    prog_nxt = '0;
                end else begin
                    prog_nxt = restart_val;
                end
            end else if (evt.addr == prefix_addr(prog)) begin
                prog_nxt = prog + STEP_W'(1);
            end else begin
                prog_nxt = restart_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prog <= '0;
        else     prog <= prog_nxt;
    end

endmodule

// File: rtl/rdseq_flag.sv
module rdseq_flag
    import rdseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_e verdict,
    output logic     prot,
    output logic     done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prot <= 1'b1;
            done <= 1'b0;
        end else begin
            done <= (verdict != VERDICT_NONE);
            case (verdict)
                VERDICT_OPEN:  prot <= 1'b0;
                VERDICT_CLOSE: prot <= 1'b1;
                default:       prot <= prot;
            endcase
        end
    end

endmodule

// File: rtl/rdseq_guard.sv
module rdseq_guard
    import rdseq_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              prot_o,
    output logic              done_o
);

    localparam int HI_W = ADDR_W - MATCH_W;

    strobe_t            strb_raw;
    strobe_t            strb_s;
    logic [MATCH_W-1:0] addr_s;
    logic [HI_W-1:0]    unused_addr_hi;
    read_evt_t          rd_evt;
    logic               wr_seen;
    verdict_e           verdict;
    logic [STEP_W-1:0]  prog;

    assign strb_raw       = '{ce_n: bus_ce_n, oe_n: bus_oe_n, we_n: bus_we_n};
    assign unused_addr_hi = bus_addr[ADDR_W-1:MATCH_W];

    rdseq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_sync_strb (
        .clk(clk), .rst(rst), .d(strb_raw), .q(strb_s)
    );

    rdseq_sync #(.W(MATCH_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
        .clk(clk), .rst(rst), .d(bus_addr[MATCH_W-1:0]), .q(addr_s)
    );

    rdseq_cycle_decode u_decode (
        .clk(clk), .rst(rst), .strb(strb_s), .addr(addr_s),
        .evt(rd_evt), .write_seen(wr_seen)
    );

    rdseq_matcher u_match (
        .clk(clk), .rst(rst), .evt(rd_evt), .write_seen(wr_seen),
        .verdict(verdict), .prog(prog)
    );

    rdseq_flag u_flag (
        .clk(clk), .rst(rst), .verdict(verdict), .prot(prot_o), .done(done_o)
    );

endmodule

// File: rtl/rdseq_guard_chk.sv
module rdseq_guard_chk
    import rdseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              prot,
    input logic              done,
    input read_evt_t         evt,
    input logic              wr_seen,
    input logic [STEP_W-1:0] prog
);

    localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(PREFIX_LEN);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (prot && !done));

    a_r2_open_tail: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !wr_seen && prog == LAST_IDX && evt.addr == TAIL_OPEN)
        |=> (!prot && done));

    a_r3_close_tail: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !wr_seen && prog == LAST_IDX && evt.addr == TAIL_CLOSE)
        |=> (prot && done));

    a_r6_restart_first: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !wr_seen && prog != LAST_IDX && evt.addr == prefix_addr('0))
        |=> (prog == STEP_W'(1)));

    a_r6_prog_range: assert property (@(posedge clk) disable iff (rst)
        prog <= LAST_IDX);

    a_r7_write_flush: assert property (@(posedge clk) disable iff (rst)
        wr_seen |=> (prog == '0));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_change_with_pulse: assert property (@(posedge clk) disable iff (rst)
        !$stable(prot) |-> done);

endmodule

bind rdseq_guard rdseq_guard_chk u_chk (
    .clk(clk), .rst(rst), .prot(prot_o), .done(done_o),
    .evt(rd_evt), .wr_seen(wr_seen), .prog(prog)
);

// File: tb/rdseq_guard_tb.sv
`timescale 1ns/1ps
module rdseq_guard_tb;

    localparam int ADDR_W = 19;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_ce_n = 1'b1;
    logic              bus_oe_n = 1'b1;
    logic              bus_we_n = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              prot_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;
    int pulses_seen = 0;
    int pulses_exp  = 0;
    bit finished = 0;

    // Bench model built from the requirements
    int m_prog = 0;
    bit m_flag = 1'b1;
    bit exp_q[$];

    always #2 clk = ~clk;

    rdseq_guard #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_addr(bus_addr), .prot_o(prot_o), .done_o(done_o)
    );

    function automatic logic [12:0] step_addr(input int i);
        case (i)
            0: return 13'h1823;
            1: return 13'h1820;
            2: return 13'h1822;
            3: return 13'h0418;
            4: return 13'h041B;
            default: return 13'h0419;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_read(input logic [12:0] a);
        int rs;
        rs = (a == 13'h1823) ? 1 : 0;
        if (m_prog == 6) begin
            if (a == 13'h041A || a == 13'h040A) begin
                m_flag = (a == 13'h040A);
                exp_q.push_back(m_flag);
                pulses_exp++;
                m_prog = 0;
            end else m_prog = rs;
        end else if (a == step_addr(m_prog)) m_prog++;
        else m_prog = rs;
    endtask

    // mode 0: chip enable held low; 1: output enable held low;
    // 2: both toggle, output enable rises first; 3: chip enable rises first
    task automatic do_read(input logic [12:0] a, input int mode);
        logic [ADDR_W-1:0] full;
        full = {6'($urandom_range(0, 63)), a};
        model_read(a);
        @(negedge clk);
        bus_addr = full; bus_we_n = 1'b1; bus_ce_n = 1'b0; bus_oe_n = 1'b0;
        cyc(3);
        case (mode)
            0: begin bus_oe_n = 1'b1; bus_addr = full ^ 19'h15555; cyc(3); end
            1: begin bus_ce_n = 1'b1; bus_addr = full ^ 19'h15555; cyc(3); end
            2: begin bus_oe_n = 1'b1; bus_addr = full ^ 19'h15555; cyc(2);
                     bus_ce_n = 1'b1; cyc(3); end
            default: begin bus_ce_n = 1'b1; bus_addr = full ^ 19'h15555; cyc(2);
                     bus_oe_n = 1'b1; cyc(3); end
        endcase
    endtask

    task automatic do_write();
        m_prog = 0;
        @(negedge clk);
        bus_oe_n = 1'b1; bus_ce_n = 1'b0; bus_we_n = 1'b0;
        cyc(3);
        bus_we_n = 1'b1; bus_ce_n = 1'b1;
        cyc(3);
    endtask

    task automatic do_prefix(input int mode, input int first, input int last);
        for (int i = first; i <= last; i++) do_read(step_addr(i), (mode < 0) ? (i % 4) : mode);
    endtask

    task automatic do_seq(input bit close, input int mode);
        do_prefix(mode, 0, 5);
        do_read(close ? 13'h040A : 13'h041A, (mode < 0) ? 2 : mode);
    endtask

    task automatic settle_check(input string req);
        cyc(4);
        check(req, 32'(prot_o), 32'(m_flag));
    endtask

    // Monitor: each pulse pops the expected flag value from the scoreboard
    always @(negedge clk) begin
        if (!rst && done_o && !finished) begin
            pulses_seen++;
            if (exp_q.size() == 0) begin
                check("R8 unexpected pulse", 32'(done_o), 32'h0);
            end else begin
                check("R8 flag at pulse", 32'(prot_o), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(5);
        check("R1 prot in reset", 32'(prot_o), 32'h1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 prot after reset", 32'(prot_o), 32'h1);
        check("R1 done after reset", 32'(done_o), 32'h0);

        // R2: open with chip enable held low
        do_seq(1'b0, 0);
        settle_check("R2 open, oe edges");
        // R3: close with output enable held low
        do_seq(1'b1, 1);
        settle_check("R3 close, ce edges");
        // R4: staggered rises, address moved after first rise
        do_seq(1'b0, 2);
        settle_check("R4 open, oe first");
        do_seq(1'b1, 3);
        settle_check("R4 close, ce first");
        do_seq(1'b0, -1);
        settle_check("R4 R5 mixed styles, random upper bits");
        // R9: open while already open
        do_seq(1'b0, 0);
        settle_check("R9 open while open");
        do_seq(1'b1, 2);
        do_seq(1'b1, 1);
        settle_check("R9 close while closed");

        // R6: broken attempt changes nothing
        do_prefix(0, 0, 3);
        do_read(13'h0777, 0);
        do_prefix(0, 4, 5);
        do_read(13'h041A, 0);
        settle_check("R6 broken attempt no effect");
        // R6: repeated first address counts as step one
        do_read(13'h1823, 1);
        do_read(13'h1823, 1);
        do_prefix(1, 1, 5);
        do_read(13'h041A, 1);
        settle_check("R6 repeated first step");
        // R6: wrong seventh equal to first address restarts
        do_prefix(3, 0, 5);
        do_read(13'h1823, 3);
        do_prefix(3, 1, 5);
        do_read(13'h040A, 3);
        settle_check("R6 seventh restarts");

        // R7: write in the middle flushes progress
        do_prefix(0, 0, 2);
        do_write();
        do_prefix(0, 3, 5);
        do_read(13'h041A, 0);
        settle_check("R7 write flush");
        do_write();
        do_seq(1'b0, 1);
        settle_check("R7 full pattern after write");

        cyc(4);
        check("R8 pulse count", 32'(pulses_seen), 32'(pulses_exp));
        check("R8 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule